// File: doc/BRIEF.md
# Multiplexed LCD Scan Timing Generator

This block paces the row scan of a multiplexed character LCD. A divided oscillator tick advances a line counter. At every line boundary the block moves a one-hot common select to the next row, so each row is driven in turn. The number of rows scanned follows two mode inputs: a two-line bit and a tall-font bit. The scan covers 8 rows for one line of 5x8 cells, 11 rows for one line of 5x11 cells and 16 rows in two-line mode. Each row is held longer in the 8- and 11-row scans than in the 16-row scan.

While one row is shown, the block fetches the pixel bits of the next row through a row/column request port. It shifts those bits serially into a local segment register with one shift pulse per column. The bits that fall out of the local register leave on a serial output, so a chain of external column drivers can pick them up on the same shift pulse. At the row boundary a latch pulse copies the local register onto the segment outputs. A frame-alternation output toggles so the panel sees an AC waveform. Before a bit is shifted, it is gated by a display enable and merged with a cursor underline and a blinking block cursor.

Top module: `lcd_scan_timing`

## Requirements
- R1: `com_sel` is one-hot, holds row 0 after reset, and steps rows 0,1,..,D-1,0 where D is 16 when `two_line`=1, 11 when `two_line`=0 and `font_tall`=1, and 8 otherwise. Only a latch event advances it.
- R2: A row lasts LINE_SHORT ticks of `osc_tick` when `two_line`=1 and LINE_LONG ticks otherwise. Cycles without `osc_tick` do not advance the scan.
- R3: In the first TOTAL_COLS ticks of a row, with TOTAL_COLS = SEG_BITS+EXT_BITS, `seg_sclk` pulses once per tick, one cycle after that tick. During these ticks `fetch_col` counts down from TOTAL_COLS-1 to 0, and `fetch_row` names the row that follows the current one.
- R4: On the last tick of a row, `seg_lclk` pulses for one cycle after the final shift pulse of that row. At the same edge `seg_out[i]` takes the pixel fetched for column i, and it holds that value until the next latch.
- R5: At every shift pulse, `ext_dout` carries the bit pushed out of the far end of the local SEG_BITS-bit register. The extension chain therefore receives columns TOTAL_COLS-1 down to SEG_BITS of the row.
- R6: `frame_m` toggles once per frame, at the latch that wraps to row 0. With M_PER_LINE=1 it toggles at every latch instead.
- R7: With `disp_on`=0 every shifted pixel is 0, so the segments and the extension data go blank. The fetched data is not changed.
- R8: With `cursor_on`=1, the last glyph row of the cursor cell is all-on. The cursor cell is the columns 5*`cur_cell`..5*`cur_cell`+4 on line `cur_line`. The last glyph row is row 7 of the line in 5x8 modes and row 10 in the 5x11 mode. Line 1 is rows 8..15 in two-line mode.
- R9: With `blink_on`=1, every row of the cursor cell is all-on during the second half of each BLINK_FRAMES-frame period. During the first half it shows the fetched pattern. The period starts with the pattern after reset.
- R10: After reset `seg_out`, `seg_sclk`, `seg_lclk`, `ext_dout` and `frame_m` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_tick | input | 1 | Divided oscillator tick enable |
| two_line | input | 1 | Two-line mode (16-row scan) |
| font_tall | input | 1 | 5x11 glyphs in one-line mode |
| disp_on | input | 1 | Display enable |
| cursor_on | input | 1 | Underline cursor enable |
| blink_on | input | 1 | Blinking block cursor enable |
| cur_line | input | 1 | Cursor text line |
| cur_cell | input | CELL_IW | Cursor cell index along the line |
| fetch_row | output | 4 | Row whose pixels are requested |
| fetch_col | output | COL_W | Column whose pixel is requested |
| fetch_bit | input | 1 | Pixel value for fetch_row/fetch_col, same cycle |
| com_sel | output | 16 | One-hot common select |
| seg_out | output | SEG_BITS | Latched segment pattern |
| seg_sclk | output | 1 | Segment shift pulse |
| seg_lclk | output | 1 | Segment latch pulse |
| ext_dout | output | 1 | Serial data to the extension chain |
| frame_m | output | 1 | AC alternation signal |

## Verification
The bench changes duty in the middle of a frame. A design that compared row or line counts for equality instead of "at or past the end" would then run past the new limit and never wrap. It gates the tick off and on and checks that the scan freezes rather than counting system clocks. The order of the extension stream is checked bit by bit, because a reversed shift direction or a missing first shift would hand the far driver the wrong columns. The cursor underline is checked on the 11-row font and on the second line. The blink is checked across phase changes that fall exactly on frame wraps, where an off-by-one frame counter shows up as a shifted half-period.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int ROWS_MAX = 16;
    localparam int ROW_W    = 4;
    localparam int CELL_W   = 5;

    // rows in one scan frame for the selected mode
    function automatic logic [4:0] scan_rows(input logic two_line, input logic font_tall);
        if (two_line)
            return 5'd16;
        else if (font_tall)
            return 5'd11;
        else
            return 5'd8;
    endfunction

    // glyph row that carries the underline cursor
    function automatic logic [ROW_W-1:0] underline_row(input logic two_line, input logic font_tall);
        return (!two_line && font_tall) ? 4'd10 : 4'd7;
    endfunction

endpackage

// File: rtl/lcd_scan_row_timer.sv
module lcd_scan_row_timer
    import lcd_scan_pkg::*;
#(
    parameter int TOTAL_COLS   = 80,
    parameter int LINE_LONG    = 400,
    parameter int LINE_SHORT   = 200,
    parameter int BLINK_FRAMES = 32,
    parameter bit M_PER_LINE   = 1'b0,
    localparam int LINE_MAX    = (LINE_LONG > LINE_SHORT) ? LINE_LONG : LINE_SHORT,
    localparam int LCNT_W      = $clog2(LINE_MAX + 1),
    localparam int COL_W       = $clog2(TOTAL_COLS),
    localparam int HALF        = (BLINK_FRAMES / 2 < 1) ? 1 : BLINK_FRAMES / 2,
    localparam int BCNT_W      = $clog2(HALF + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                osc_tick,
    input  logic                two_line,
    input  logic                font_tall,
    output logic [ROWS_MAX-1:0] com_sel,
    output logic                frame_m,
    output logic                blink_phase,
    output logic                shift_en,
    output logic                latch_en,
    output logic [COL_W-1:0]    shift_col,
    output logic [ROW_W-1:0]    fetch_row
);

    typedef struct packed {
        logic [LCNT_W-1:0]   line;
        logic [ROW_W-1:0]    row;
        logic [ROWS_MAX-1:0] com;
        logic                m;
        logic [BCNT_W-1:0]   bcnt;
        logic                bph;
    } tstate_t;

    tstate_t s_d, s_q;

    logic [4:0]        rows_d;
    logic [LCNT_W-1:0] len_m1_d;
    logic              line_end_d;
    logic [4:0]        row_inc_d;
    logic [ROW_W-1:0]  row_nxt_d;
    logic              frame_end_d;

    always_comb begin
        rows_d      = scan_rows(two_line, font_tall);
        len_m1_d    = two_line ? LCNT_W'(LINE_SHORT - 1) : LCNT_W'(LINE_LONG - 1);
        line_end_d  = (s_q.line >= len_m1_d);
        row_inc_d   = {1'b0, s_q.row} + 5'd1;
        row_nxt_d   = (row_inc_d >= rows_d) ? '0 : row_inc_d[ROW_W-1:0];
        frame_end_d = (row_nxt_d == '0);

        s_d = s_q;
        if (osc_tick) begin
            if (line_end_d) begin
                s_d.line = '0;
                s_d.row  = row_nxt_d;
                s_d.com  = ROWS_MAX'(1) << row_nxt_d;
                if (M_PER_LINE || frame_end_d)
                    s_d.m = ~s_q.m;
                if (frame_end_d) begin
                    if (s_q.bcnt == BCNT_W'(HALF - 1)) begin
                        s_d.bcnt = '0;
                        s_d.bph  = ~s_q.bph;
                    end else begin
                        s_d.bcnt = s_q.bcnt + BCNT_W'(1);
                    end
                end
            end else begin
                s_d.line = s_q.line + LCNT_W'(1);
            end
        end

        shift_en    = osc_tick && (s_q.line < LCNT_W'(TOTAL_COLS));
        latch_en    = osc_tick && line_end_d;
        shift_col   = COL_W'(TOTAL_COLS - 1) - COL_W'(s_q.line);
        fetch_row   = row_nxt_d;
        com_sel     = s_q.com;
        frame_m     = s_q.m;
        blink_phase = s_q.bph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{line: '0, row: '0, com: ROWS_MAX'(1), m: 1'b0, bcnt: '0, bph: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    // R1: exactly one common line is selected
    p_com_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(com_sel) == 1);

    // R2: the scan is frozen while no tick arrives
    p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> $stable(s_q.line) && $stable(com_sel));

    // R3: shifting never overlaps the row boundary
    p_shift_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && latch_en));

    // R6: alternation only moves at a row boundary
    p_m_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(frame_m));

endmodule

// File: rtl/lcd_scan_pixel.sv
module lcd_scan_pixel
    import lcd_scan_pkg::*;
#(
    parameter int COL_W  = 7,
    parameter int CELL_IW = 4
) (
    input  logic [ROW_W-1:0]   row,
    input  logic [COL_W-1:0]   col,
    input  logic               two_line,
    input  logic               font_tall,
    input  logic               disp_on,
    input  logic               cursor_on,
    input  logic               blink_on,
    input  logic               blink_phase,
    input  logic               cur_line,
    input  logic [CELL_IW-1:0] cur_cell,
    input  logic               fetch_bit,
    output logic               pix
);

    logic [COL_W-1:0] cell_d;
    logic             line_of_row_d;
    logic [ROW_W-1:0] glyph_row_d;
    logic             in_cell_d;
    logic             underline_d;
    logic             block_d;

    always_comb begin
        cell_d        = col / COL_W'(CELL_W);
        line_of_row_d = two_line & row[ROW_W-1];
        glyph_row_d   = two_line ? {1'b0, row[ROW_W-2:0]} : row;
        in_cell_d     = (cell_d == COL_W'(cur_cell)) && (line_of_row_d == cur_line);
        underline_d   = cursor_on && in_cell_d &&
                        (glyph_row_d == underline_row(two_line, font_tall));
        block_d       = blink_on && blink_phase && in_cell_d;
        pix           = disp_on && (fetch_bit || underline_d || block_d);
    end

endmodule

// File: rtl/lcd_scan_seg_shift.sv
module lcd_scan_seg_shift #(
    parameter int SEG_BITS = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                latch_en,
    input  logic                pix_in,
    input  logic                disp_on,
    output logic [SEG_BITS-1:0] seg_out,
    output logic                seg_sclk,
    output logic                seg_lclk,
    output logic                ext_dout
);

    typedef struct packed {
        logic [SEG_BITS-1:0] sh;
        logic [SEG_BITS-1:0] lat;
        logic                sclk;
        logic                lclk;
        logic                dout;
    } sstate_t;

    sstate_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sclk = shift_en;
        s_d.lclk = latch_en;
        if (shift_en) begin
            s_d.dout = s_q.sh[SEG_BITS-1];
            s_d.sh   = {s_q.sh[SEG_BITS-2:0], pix_in};
        end
        if (latch_en)
            s_d.lat = s_q.sh;

        seg_out  = s_q.lat;
        seg_sclk = s_q.sclk;
        seg_lclk = s_q.lclk;
        ext_dout = s_q.dout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R4: segment outputs move only at a latch
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(seg_out));

    // R4: latch pulse is a single cycle
    p_lclk_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seg_lclk |=> !seg_lclk);

    // R7: with the display off the entering bit is blank
    p_blank_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !disp_on) |=> !s_q.sh[0]);

endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
    import lcd_scan_pkg::*;
#(
    parameter int SEG_BITS     = 40,
    parameter int EXT_BITS     = 40,
    parameter int LINE_LONG    = 400,
    parameter int LINE_SHORT   = 200,
    parameter int BLINK_FRAMES = 32,
    parameter bit M_PER_LINE   = 1'b0,
    localparam int TOTAL_COLS  = SEG_BITS + EXT_BITS,
    localparam int COL_W       = $clog2(TOTAL_COLS),
    localparam int CELL_CNT    = (TOTAL_COLS + CELL_W - 1) / CELL_W,
    localparam int CELL_IW     = (CELL_CNT > 1) ? $clog2(CELL_CNT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                osc_tick,
    input  logic                two_line,
    input  logic                font_tall,
    input  logic                disp_on,
    input  logic                cursor_on,
    input  logic                blink_on,
    input  logic                cur_line,
    input  logic [CELL_IW-1:0]  cur_cell,
    output logic [ROW_W-1:0]    fetch_row,
    output logic [COL_W-1:0]    fetch_col,
    input  logic                fetch_bit,
    output logic [ROWS_MAX-1:0] com_sel,
    output logic [SEG_BITS-1:0] seg_out,
    output logic                seg_sclk,
    output logic                seg_lclk,
    output logic                ext_dout,
    output logic                frame_m
);

    logic shift_en;
    logic latch_en;
    logic blink_phase;
    logic pix;

    lcd_scan_row_timer #(
        .TOTAL_COLS  (TOTAL_COLS),
        .LINE_LONG   (LINE_LONG),
        .LINE_SHORT  (LINE_SHORT),
        .BLINK_FRAMES(BLINK_FRAMES),
        .M_PER_LINE  (M_PER_LINE)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_tick   (osc_tick),
        .two_line   (two_line),
        .font_tall  (font_tall),
        .com_sel    (com_sel),
        .frame_m    (frame_m),
        .blink_phase(blink_phase),
        .shift_en   (shift_en),
        .latch_en   (latch_en),
        .shift_col  (fetch_col),
        .fetch_row  (fetch_row)
    );

    lcd_scan_pixel #(
        .COL_W  (COL_W),
        .CELL_IW(CELL_IW)
    ) u_pixel (
        .row        (fetch_row),
        .col        (fetch_col),
        .two_line   (two_line),
        .font_tall  (font_tall),
        .disp_on    (disp_on),
        .cursor_on  (cursor_on),
        .blink_on   (blink_on),
        .blink_phase(blink_phase),
        .cur_line   (cur_line),
        .cur_cell   (cur_cell),
        .fetch_bit  (fetch_bit),
        .pix        (pix)
    );

    lcd_scan_seg_shift #(
        .SEG_BITS(SEG_BITS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .latch_en(latch_en),
        .pix_in  (pix),
        .disp_on (disp_on),
        .seg_out (seg_out),
        .seg_sclk(seg_sclk),
        .seg_lclk(seg_lclk),
        .ext_dout(ext_dout)
    );

    // R3: a shift pulse follows every shifting tick, before the latch
    p_sclk_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> seg_sclk && !seg_lclk);

endmodule

// File: tb/test_lcd_scan_timing.sv
module test_lcd_scan_timing;

    localparam int SEG = 8;
    localparam int EXT = 8;
    localparam int TOT = SEG + EXT;
    localparam int LL  = 24;
    localparam int LS  = 20;
    localparam int BF  = 4;
    localparam int CW  = 4;
    localparam int CIW = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, osc_tick = 1'b0, two_line = 1'b0, font_tall = 1'b0;
    logic disp_on = 1'b0, cursor_on = 1'b0, blink_on = 1'b0, cur_line = 1'b0;
    logic [CIW-1:0] cur_cell = '0;

    logic [3:0] fr, fr2;
    logic [CW-1:0] fc, fc2;
    logic fb, fb2;
    logic [15:0] com, com2;
    logic [SEG-1:0] seg, seg2;
    logic sclk, lclk, dout, mm, sclk2, lclk2, dout2, mm2;

    function automatic bit pat(input int r, input int c);
        return (((r * 3 + c) % 5) == 0) || (c == r);
    endfunction

    assign fb  = pat(int'(fr), int'(fc));
    assign fb2 = pat(int'(fr2), int'(fc2));

    lcd_scan_timing #(.SEG_BITS(SEG), .EXT_BITS(EXT), .LINE_LONG(LL), .LINE_SHORT(LS),
                      .BLINK_FRAMES(BF), .M_PER_LINE(1'b0)) i_lcd_scan_timing (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .two_line(two_line),
        .font_tall(font_tall), .disp_on(disp_on), .cursor_on(cursor_on),
        .blink_on(blink_on), .cur_line(cur_line), .cur_cell(cur_cell),
        .fetch_row(fr), .fetch_col(fc), .fetch_bit(fb), .com_sel(com),
        .seg_out(seg), .seg_sclk(sclk), .seg_lclk(lclk), .ext_dout(dout), .frame_m(mm));

    lcd_scan_timing #(.SEG_BITS(SEG), .EXT_BITS(EXT), .LINE_LONG(LL), .LINE_SHORT(LS),
                      .BLINK_FRAMES(BF), .M_PER_LINE(1'b1)) i_lcd_scan_timing_ml (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .two_line(two_line),
        .font_tall(font_tall), .disp_on(disp_on), .cursor_on(cursor_on),
        .blink_on(blink_on), .cur_line(cur_line), .cur_cell(cur_cell),
        .fetch_row(fr2), .fetch_col(fc2), .fetch_bit(fb2), .com_sel(com2),
        .seg_out(seg2), .seg_sclk(sclk2), .seg_lclk(lclk2), .ext_dout(dout2), .frame_m(mm2));

    int nchk = 0;
    int nerr = 0;
    bit started = 0;
    int tmode = 0;
    string ptag = "R1";

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model state
    int m_line = 0, m_row = 0, m_bcnt = 0;
    bit m_m = 0, m_ml = 0, m_bph = 0, m_sclk = 0, m_lclk = 0, m_dout = 0;
    bit m_sh[$];
    logic [SEG-1:0] m_lat = '0;

    function automatic int rows_now();
        return two_line ? 16 : (font_tall ? 11 : 8);
    endfunction

    function automatic int next_row();
        return (m_row + 1 >= rows_now()) ? 0 : m_row + 1;
    endfunction

    function automatic bit exp_pix(input int r, input int c);
        bit in_line;
        bit in_cell;
        int grow;
        int last;
        in_line = two_line ? ((r >= 8) == cur_line) : (cur_line == 1'b0);
        in_cell = in_line && ((c / 5) == int'(cur_cell));
        grow    = two_line ? (r % 8) : r;
        last    = (!two_line && font_tall) ? 10 : 7;
        return disp_on && (pat(r, c) || (cursor_on && in_cell && grow == last)
                           || (blink_on && m_bph && in_cell));
    endfunction

    initial begin
        for (int i = 0; i < SEG; i++) m_sh.push_back(1'b0);
    end

    always @(posedge clk) begin
        int len;
        int nxt;
        bit sh;
        bit le;
        bit p;
        if (!rst_n) begin
            m_line = 0; m_row = 0; m_bcnt = 0;
            m_m = 0; m_ml = 0; m_bph = 0; m_sclk = 0; m_lclk = 0; m_dout = 0;
            m_lat = '0;
            for (int i = 0; i < SEG; i++) m_sh[i] = 1'b0;
        end else begin
            len = two_line ? LS : LL;
            nxt = next_row();
            sh  = osc_tick && (m_line < TOT);
            le  = osc_tick && (m_line >= len - 1);
            m_sclk = sh;
            m_lclk = le;
            if (sh) begin
                p = exp_pix(nxt, TOT - 1 - m_line);
                m_dout = m_sh.pop_front();
                m_sh.push_back(p);
            end
            if (le) begin
                for (int i = 0; i < SEG; i++) m_lat[i] = m_sh[SEG - 1 - i];
                m_row = nxt;
                m_ml  = ~m_ml;
                if (nxt == 0) begin
                    m_m = ~m_m;
                    m_bcnt++;
                    if (m_bcnt == BF / 2) begin
                        m_bcnt = 0;
                        m_bph  = ~m_bph;
                    end
                end
                m_line = 0;
            end else if (osc_tick) begin
                m_line++;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && started) begin
            chk("R1 common select", 64'(com), 64'(16'(1) << m_row));
            chk($sformatf("R4 segments %s", ptag), 64'(seg), 64'(m_lat));
            chk("R3 shift pulse", 64'(sclk), 64'(m_sclk));
            chk("R2 latch pulse", 64'(lclk), 64'(m_lclk));
            chk($sformatf("R5 extension data %s", ptag), 64'(dout), 64'(m_dout));
            chk("R6 frame alternation", 64'(mm), 64'(m_m));
            chk("R6 per-line alternation", 64'(mm2), 64'(m_ml));
            if (m_line < TOT) begin
                chk("R3 fetch column", 64'(fc), 64'(TOT - 1 - m_line));
                chk("R3 fetch row", 64'(fr), 64'(next_row()));
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #5;
            case (tmode)
                0: osc_tick = 1'b1;
                1: osc_tick = ~osc_tick;
                default: osc_tick = 1'b0;
            endcase
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset common", 64'(com), 64'h1);
        chk("R10 reset segments", 64'(seg), 64'h0);
        chk("R10 reset pulses", 64'({sclk, lclk}), 64'h0);
        chk("R10 reset dout", 64'(dout), 64'h0);
        chk("R10 reset alternation", 64'(mm), 64'h0);
        @(posedge clk);
        #5;
        rst_n = 1'b1; disp_on = 1'b1; started = 1; tmode = 0;
        ptag = "R1"; step(1200);
        cursor_on = 1'b1; cur_cell = 2'd1; ptag = "R8"; step(800);
        font_tall = 1'b1; tmode = 1; ptag = "R8 R2"; step(2200);
        two_line = 1'b1; cur_line = 1'b1; cur_cell = 2'd2; blink_on = 1'b1;
        tmode = 0; ptag = "R9"; step(2200);
        disp_on = 1'b0; ptag = "R7"; step(600);
        disp_on = 1'b1; tmode = 2; ptag = "R2"; step(60);
        tmode = 0; two_line = 1'b0; font_tall = 1'b0; step(600);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule